// File: doc/BRIEF.md
# SYN Flood Limiter

This block is a stateful per-session filter in a packet pipeline. A parser upstream hands it, for each packet, the TCP SYN and ACK flags, a session key and the TCP source port. The session key is the address pair. The block hashes the key into a table of session entries. Each entry holds two separate values: the source port of the latest SYN seen for that session, and a count of repeated SYN attempts.

A SYN that arrives with a new source port counts as one more attempt. Once the attempt count of a session rises above a configured threshold, its SYN packets are dropped. A bare ACK from the same session means a handshake finished, so it clears the count. The block returns one forward-or-drop decision per packet, two clock cycles after the packet is presented.

Top module: `syn_flood_limiter`

## Requirements
- R1: After reset, `decValid` and `decDrop` are low. Every table entry holds stored port 0 and attempt count 0. A SYN with source port 0 on a fresh entry therefore leaves the count at 0.
- R2: A packet presented with `pktValid` high in a cycle gets its decision on `decValid`/`decDrop` exactly two rising edges later. A cycle without a packet gives `decValid` low two edges later.
- R3: The table index is the low 10 bits of a CRC-16 of `sessKey`. The CRC uses polynomial 0x1021 and initial value 0xFFFF, and processes the key bits from the most significant bit downward with no final XOR. Two keys with the same index share one entry.
- R4: A packet with the SYN flag set whose source port differs from the stored port adds one to the entry's count. The stored port then becomes the new source port.
- R5: A SYN whose source port equals the stored port leaves both the count and the stored port unchanged.
- R6: A packet is dropped exactly when its SYN flag is set and the entry's count, after this packet's update, is greater than the threshold.
- R7: A packet with ACK set and SYN clear is forwarded and sets the entry's count to 0. The stored port is kept.
- R8: A packet with SYN clear and ACK clear is forwarded and leaves the entry unchanged.
- R9: The count saturates at 2^8-1 = 255 and does not wrap.
- R10: Packets may arrive in back-to-back cycles. Each packet's decision reflects every update made by the packets before it, including one to the same entry in the previous cycle.
- R11: The threshold is taken from `cfgThreshold` in the same cycle as the packet it applies to.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pktValid | input | 1 | A packet is presented this cycle |
| pktSyn | input | 1 | TCP SYN flag of the packet |
| pktAck | input | 1 | TCP ACK flag of the packet |
| sessKey | input | 64 | Session key (address pair) |
| srcPort | input | 16 | TCP source port |
| cfgThreshold | input | 8 | Attempt count above which SYNs are dropped |
| decValid | output | 1 | Decision valid |
| decDrop | output | 1 | 1 = drop the packet, 0 = forward |

## Verification
A directed run on one session steps through SYNs with a new port and SYNs with a repeated port. It mixes in flagless packets and a completing ACK. This separates counting on a port change from counting every SYN, and it shows that a plain packet leaves the entry alone while an ACK clears the count but not the port. A second key forced onto the same index tells a correct hash from one that spreads the two keys over different entries. A run of 300 attempts against a threshold of 254 tells saturation from wrap-around. Back-to-back random traffic over a few sessions, with the threshold changed between segments, is compared against a bench model. This exposes stale reads between consecutive packets and any threshold applied to the wrong packet.

// File: rtl/syn_lim_pkg.sv
package syn_lim_pkg;

  // Strobes from the control stage to the datapath for the packet now in stage 1.
  typedef struct packed {
    logic live;     // a packet occupies stage 1
    logic synSeen;  // that packet carries SYN
    logic bump;     // increment attempt count and store the new port
    logic clear;    // handshake completed: zero the attempt count
  } limStb_t;

endpackage

// File: rtl/syn_lim_ctrl.sv
module syn_lim_ctrl
  import syn_lim_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pktValid,
  input  logic    pktSyn,
  input  logic    pktAck,
  input  logic    portDiffer,
  output limStb_t stb
);

  logic vldQ;
  logic synQ;
  logic ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldQ <= 1'b0;
      synQ <= 1'b0;
      ackQ <= 1'b0;
    end else begin
      vldQ <= pktValid;
      if (pktValid) begin
        synQ <= pktSyn;
        ackQ <= pktAck;
      end
    end
  end

  always_comb begin
    stb.live    = vldQ;
    stb.synSeen = vldQ & synQ;
    stb.bump    = vldQ & synQ & portDiffer;
    stb.clear   = vldQ & ~synQ & ackQ;
  end

endmodule

// File: rtl/syn_lim_dp.sv
module syn_lim_dp
  import syn_lim_pkg::*;
#(
  parameter int KEY_W  = 64,
  parameter int PORT_W = 16,
  parameter int CNT_W  = 8,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktValid,
  input  logic [KEY_W-1:0]  sessKey,
  input  logic [PORT_W-1:0] srcPort,
  input  logic [CNT_W-1:0]  cfgThreshold,
  input  limStb_t           stb,
  output logic              portDiffer,
  output logic              decValid,
  output logic              decDrop
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Bitwise CRC-16 over the key, MSB first; only the index bits are kept.
  function automatic logic [IDX_W-1:0] keyIndex(input logic [KEY_W-1:0] key);
    logic [15:0] crc;
    logic fb;
    crc = CRC_INIT;
    for (int b = KEY_W - 1; b >= 0; b--) begin
      fb  = crc[15] ^ key[b];
      crc = {crc[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return crc[IDX_W-1:0];
  endfunction

  // Stage 1 registers
  logic [IDX_W-1:0]  idxQ;
  logic [PORT_W-1:0] portQ;
  logic [CNT_W-1:0]  thrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      portQ <= '0;
      thrQ  <= '0;
    end else if (pktValid) begin
      idxQ  <= keyIndex(sessKey);
      portQ <= srcPort;
      thrQ  <= cfgThreshold;
    end
  end

  // Session table: two separate arrays
  logic [PORT_W-1:0] portMem [DEPTH];
  logic [CNT_W-1:0]  cntMem  [DEPTH];

  logic [PORT_W-1:0] curPort;
  logic [CNT_W-1:0]  curCnt;
  logic [CNT_W-1:0]  nextCnt;

  always_comb begin
    curPort    = portMem[idxQ];
    curCnt     = cntMem[idxQ];
    portDiffer = (curPort != portQ);
    if (stb.clear)
      nextCnt = '0;
    else if (stb.bump)
      nextCnt = (curCnt == CNT_MAX) ? curCnt : curCnt + 1'b1;
    else
      nextCnt = curCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        portMem[i] <= '0;
        cntMem[i]  <= '0;
      end
    end else begin
      if (stb.bump)
        portMem[idxQ] <= portQ;
      if (stb.bump || stb.clear)
        cntMem[idxQ] <= nextCnt;
    end
  end

  // Decision register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid <= 1'b0;
      decDrop  <= 1'b0;
    end else begin
      decValid <= stb.live;
      decDrop  <= stb.synSeen && (nextCnt > thrQ);
    end
  end

endmodule

// File: rtl/syn_flood_limiter.sv
module syn_flood_limiter
  import syn_lim_pkg::*;
#(
  parameter int KEY_W  = 64,
  parameter int PORT_W = 16,
  parameter int CNT_W  = 8,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktValid,
  input  logic              pktSyn,
  input  logic              pktAck,
  input  logic [KEY_W-1:0]  sessKey,
  input  logic [PORT_W-1:0] srcPort,
  input  logic [CNT_W-1:0]  cfgThreshold,
  output logic              decValid,
  output logic              decDrop
);

  limStb_t ctlStb;
  logic    portDiffer;

  syn_lim_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pktValid   (pktValid),
    .pktSyn     (pktSyn),
    .pktAck     (pktAck),
    .portDiffer (portDiffer),
    .stb        (ctlStb)
  );

  syn_lim_dp #(
    .KEY_W  (KEY_W),
    .PORT_W (PORT_W),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .pktValid     (pktValid),
    .sessKey      (sessKey),
    .srcPort      (srcPort),
    .cfgThreshold (cfgThreshold),
    .stb          (ctlStb),
    .portDiffer   (portDiffer),
    .decValid     (decValid),
    .decDrop      (decDrop)
  );

endmodule

// File: rtl/syn_lim_chk.sv
module syn_lim_chk
  import syn_lim_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    pktValid,
  input logic    decValid,
  input logic    decDrop,
  input limStb_t stb
);

  // R2: a presented packet reaches stage 1 on the next edge
  assert_stage_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |=> stb.live);

  // R2: the decision follows stage 1 by one edge
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    decValid == $past(stb.live));

  // R6: a drop is always a valid decision
  assert_drop_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    decDrop |-> decValid);

  // R6: only a SYN packet can be dropped
  assert_drop_syn_R6: assert property (@(posedge clk) disable iff (!rstN)
    decDrop |-> $past(stb.synSeen));

  // R7: a completing ACK is forwarded
  assert_ack_forward_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> !decDrop);

endmodule

bind syn_flood_limiter syn_lim_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pktValid (pktValid),
  .decValid (decValid),
  .decDrop  (decDrop),
  .stb      (ctlStb)
);

// File: tb/sim_syn_flood_limiter.sv
`timescale 1ns/1ps
module sim_syn_flood_limiter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktValid = 1'b0;
  logic        pktSyn = 1'b0;
  logic        pktAck = 1'b0;
  logic [63:0] sessKey = '0;
  logic [15:0] srcPort = '0;
  logic [7:0]  cfgThreshold = '0;
  logic        decValid;
  logic        decDrop;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  syn_flood_limiter u0 (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktSyn(pktSyn), .pktAck(pktAck),
    .sessKey(sessKey), .srcPort(srcPort), .cfgThreshold(cfgThreshold),
    .decValid(decValid), .decDrop(decDrop)
  );

  // Reference model of the session table
  logic [15:0] mPort [1024];
  int          mCnt  [1024];

  function automatic logic [9:0] refIdx(input logic [63:0] k);
    logic [15:0] c;
    logic f;
    c = 16'hFFFF;
    for (int b = 63; b >= 0; b--) begin
      f = c[15] ^ k[b];
      c = {c[14:0], 1'b0};
      if (f) c = c ^ 16'h1021;
    end
    return c[9:0];
  endfunction

  function automatic logic [63:0] findKey(input logic [63:0] base, input logic [9:0] want);
    logic [63:0] k;
    k = base;
    while (refIdx(k) != want) k = k + 64'd1;
    return k;
  endfunction

  function automatic logic modelStep(input logic [63:0] k, input logic [15:0] p,
                                     input logic s, input logic a, input int thr);
    logic [9:0] ix;
    ix = refIdx(k);
    if (s) begin
      if (mPort[ix] != p) begin
        if (mCnt[ix] < 255) mCnt[ix] = mCnt[ix] + 1;
        mPort[ix] = p;
      end
      return (mCnt[ix] > thr);
    end
    if (a) mCnt[ix] = 0;
    return 1'b0;
  endfunction

  task automatic expectBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Isolated packet: drive, let it pass two edges, sample the decision.
  task automatic sendOne(input logic [63:0] k, input logic [15:0] p, input logic s,
                         input logic a, input logic expDrop, input string tag);
    logic md;
    @(negedge clk);
    pktValid = 1'b1; pktSyn = s; pktAck = a; sessKey = k; srcPort = p;
    md = modelStep(k, p, s, a, int'(cfgThreshold));
    @(negedge clk);
    pktValid = 1'b0;
    @(negedge clk);
    expectBit({tag, " valid"}, decValid, 1'b1);
    expectBit({tag, " drop"}, decDrop, expDrop);
    if (md !== expDrop) $display("note: model and literal differ for %s", tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] keyA, keyB, keyC, keyD, keyE;
    logic [63:0] rk [6];
    logic        q1v, q1d, q2v, q2d;
    logic        nv, nd;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 1024; i++) begin mPort[i] = '0; mCnt[i] = 0; end

    keyA = findKey(64'h0A00_0001_0A00_0002, 10'd5);
    keyB = findKey(64'hC0A8_0101_C0A8_0202, 10'd5);
    keyC = findKey(64'h0A00_0003_0A00_0004, 10'd6);
    keyD = findKey(64'h0A00_0005_0A00_0006, 10'd7);
    keyE = findKey(64'h0A00_0007_0A00_0008, 10'd8);
    for (int i = 0; i < 6; i++)
      rk[i] = findKey(64'h1000_0000_2000_0000 + 64'(i) * 64'h1_0000_0000, 10'(20 + i));

    repeat (3) @(posedge clk);
    @(negedge clk);
    expectBit("R1 reset valid", decValid, 1'b0);
    expectBit("R1 reset drop", decDrop, 1'b0);
    rstN = 1'b1;

    // R1: fresh entry has stored port 0
    cfgThreshold = 8'd0;
    sendOne(keyE, 16'd0, 1, 0, 1'b0, "R1 port0 no bump");
    sendOne(keyE, 16'd5, 1, 0, 1'b1, "R1 first new port");

    // Main sequence on keyA, threshold 2
    cfgThreshold = 8'd2;
    sendOne(keyA, 16'd100, 1, 0, 1'b0, "R4 first SYN");
    sendOne(keyA, 16'd100, 1, 0, 1'b0, "R5 repeat port");
    sendOne(keyA, 16'd101, 1, 0, 1'b0, "R6 count equals thr");
    sendOne(keyA, 16'd102, 1, 0, 1'b1, "R6 count above thr");
    sendOne(keyA, 16'd102, 1, 0, 1'b1, "R5 repeat still dropped");
    sendOne(keyA, 16'd7,   0, 0, 1'b0, "R8 plain forwarded");
    sendOne(keyA, 16'd102, 1, 0, 1'b1, "R8 state unchanged");
    sendOne(keyA, 16'd9,   0, 1, 1'b0, "R7 ack forwarded");
    sendOne(keyA, 16'd102, 1, 0, 1'b0, "R7 count cleared port kept");
    sendOne(keyA, 16'd103, 1, 0, 1'b0, "R4 count restarts");

    // R3: keyB shares keyA's entry
    sendOne(keyB, 16'd103, 1, 0, 1'b0, "R3 shared port");
    sendOne(keyB, 16'd104, 1, 0, 1'b0, "R3 shared count 2");
    sendOne(keyA, 16'd105, 1, 0, 1'b1, "R3 shared count 3");
    sendOne(keyC, 16'd1,   1, 0, 1'b0, "R3 separate entry");

    // R11: threshold travels with the packet
    cfgThreshold = 8'd3;
    sendOne(keyA, 16'd105, 1, 0, 1'b0, "R11 raised thr");
    cfgThreshold = 8'd0;
    sendOne(keyC, 16'd1,   1, 0, 1'b1, "R11 lowered thr");

    // R9: saturation
    cfgThreshold = 8'd254;
    for (int n = 0; n < 300; n++)
      sendOne(keyD, (n % 2 == 0) ? 16'd10 : 16'd11, 1, 0, (n >= 254), "R9 climb");
    sendOne(keyD, 16'd12, 1, 0, 1'b1, "R9 saturated");
    cfgThreshold = 8'd255;
    sendOne(keyD, 16'd13, 1, 0, 1'b0, "R9 at max not above");

    // R10: back-to-back random traffic against the model
    q1v = 0; q1d = 0; q2v = 0; q2d = 0;
    for (int n = 0; n < 3002; n++) begin
      @(negedge clk);
      expectBit("R10 valid", decValid, q2v);
      if (q2v) expectBit("R10 drop", decDrop, q2d);
      q2v = q1v; q2d = q1d;
      nv = 0; nd = 0;
      if (n < 3000) begin
        if (n % 400 == 0) cfgThreshold = 8'($urandom_range(0, 5));
        nv = ($urandom_range(0, 9) < 8);
        pktValid = nv;
        pktSyn   = ($urandom_range(0, 1) == 1);
        pktAck   = ($urandom_range(0, 9) < 3);
        sessKey  = rk[$urandom_range(0, 5)];
        srcPort  = 16'(200 + $urandom_range(0, 2));
        if (nv) nd = modelStep(sessKey, srcPort, pktSyn, pktAck, int'(cfgThreshold));
      end else begin
        pktValid = 1'b0;
      end
      q1v = nv; q1d = nd;
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule